// File: doc/BRIEF.md
# Link SECDED ECC Codec

This block guards a low-latency chip-to-chip serial link against bit errors. It does not use a checksum with retransmission. The transmit side takes one 64-bit payload word per valid cycle and emits a 72-bit codeword: an extended Hamming code that can correct any single flipped bit and detect any two flipped bits. The receive side takes 72-bit codewords from the deserializer. It repairs a single flipped bit wherever it lies, raises a flag when the damage is beyond repair, and always delivers a word after a fixed delay. Nothing is buffered for resending.

The link mostly sees isolated, randomly placed single-bit flips, so the code is sized for that case. Each direction is a single register stage. The encoder and decoder paths are independent, so one instance can serve both ends of a full-duplex lane. Two saturating counters record how many received words were repaired and how many could not be repaired.

Top module: `link_secded_codec`

## Requirements
- R1: The codeword bit at position p (0 to 71) is laid out as follows. Position 0 holds even parity over the whole 72-bit word. Positions 1, 2, 4, 8, 16, 32 and 64 hold the check bits. The check bit at position 2^b makes the XOR of all positions that have bit b set, including itself, equal to zero. The 64 data bits fill the remaining positions in ascending order, so data bit 0 goes to position 3. Payload 64'h1 therefore encodes to 72'hF.
- R2: `enc_valid` and `enc_word` appear exactly one cycle after `in_valid`/`in_data`. When `in_valid` is low, `enc_valid` is low in the following cycle and `enc_word` keeps its last value.
- R3: A received word with zero syndrome and even parity comes out one cycle later as its data bits, with `out_valid` high and both flags low.
- R4: A received word with odd parity and a syndrome between 0 and 71 has exactly one bit corrected: the bit whose position equals the syndrome, where syndrome 0 means the parity bit. The repaired data comes out with `out_corrected` high.
- R5: A received word with even parity and a nonzero syndrome (two flipped bits) raises `out_uncorrectable`. The data bits of the received word are delivered unmodified.
- R6: A received word with odd parity and a syndrome of 72 or more (some odd error counts of three or more) also raises `out_uncorrectable`, and its data bits are delivered unmodified.
- R7: In the cycle after `rx_valid` is low, `out_valid` and both flags are low and `out_data` keeps its last value. The two flags are never high together.
- R8: `corr_count` rises by one with each corrected word and `uncorr_count` rises by one with each uncorrectable word. The change becomes visible in the same cycle as the matching flag. Each counter stops at all ones.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload word present for encoding |
| in_data | input | 64 | Payload word |
| enc_valid | output | 1 | Codeword present on `enc_word` |
| enc_word | output | 72 | Encoded codeword toward the serializer |
| rx_valid | input | 1 | Received codeword present |
| rx_word | input | 72 | Received codeword from the deserializer |
| out_valid | output | 1 | Decoded word present |
| out_data | output | 64 | Decoded payload |
| out_corrected | output | 1 | A single bit was repaired in this word |
| out_uncorrectable | output | 1 | The damage in this word could not be repaired |
| corr_count | output | CNT_W | Saturating count of repaired words |
| uncorr_count | output | CNT_W | Saturating count of unrepairable words |

## Verification
The properties assume that `in_valid` and `rx_valid` are never unknown after reset. They also assume that the received word is only looked at in cycles where `rx_valid` is high, so the hold behaviour is checked only against the last accepted word. The stimulus drives every input to a defined value on the falling edge and builds each received word from a known payload with a chosen set of flipped positions. This means the damage class of every word (clean, one flip, two flips, or three flips whose syndrome lands above 71) is known in advance. The three-flip case uses positions whose XOR exceeds 71, so it reaches the beyond-range branch deliberately rather than by chance.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int unsigned DATA_W   = 64;
  localparam int unsigned HAM_W    = 7;
  localparam int unsigned CODE_W   = DATA_W + HAM_W + 1;
  localparam int unsigned LAST_POS = CODE_W - 1;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [HAM_W-1:0]  synd_t;

  typedef enum logic [1:0] {
    KIND_CLEAN  = 2'd0,
    KIND_SINGLE = 2'd1,
    KIND_DOUBLE = 2'd2,
    KIND_BEYOND = 2'd3
  } rx_kind_e;

  function automatic logic is_pow2(input int unsigned p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // Scatter payload bits into the non-check positions, ascending.
  function automatic code_t place_data(input data_t d);
    code_t       cw;
    int unsigned k;
    cw = '0;
    k  = 0;
    for (int unsigned pos = 1; pos <= LAST_POS; pos++) begin
      if (!is_pow2(pos)) begin
        cw[pos] = d[k];
        k++;
      end
    end
    return cw;
  endfunction

  // Gather payload bits back out of a codeword.
  function automatic data_t extract_data(input code_t cw);
    data_t       d;
    int unsigned k;
    d = '0;
    k = 0;
    for (int unsigned pos = 1; pos <= LAST_POS; pos++) begin
      if (!is_pow2(pos)) begin
        d[k] = cw[pos];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of the indices of all set bits at positions 1..LAST_POS.
  function automatic synd_t syndrome_of(input code_t cw);
    synd_t s;
    s = '0;
    for (int unsigned pos = 1; pos <= LAST_POS; pos++) begin
      if (cw[pos]) s = s ^ synd_t'(pos);
    end
    return s;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  data_t in_data,
  output logic  enc_valid,
  output code_t enc_word
);

  code_t placed;
  synd_t fill;
  code_t word_c;

  code_t word_d, word_q;
  logic  valid_d, valid_q;

  always_comb begin
    placed = place_data(in_data);
    fill   = syndrome_of(placed);
  end

  // Check bits are the syndrome of the data-only word.
  always_comb begin
    word_c = placed;
    for (int unsigned b = 0; b < HAM_W; b++) begin
      word_c[1 << b] = fill[b];
    end
    word_c[0] = ^word_c[CODE_W-1:1];
  end

  always_comb begin
    valid_d = in_valid;
    word_d  = in_valid ? word_c : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign enc_valid = valid_q;
  assign enc_word  = word_q;

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  code_t rx_word,
  output logic  hit_single,
  output logic  hit_fail,
  output logic  out_valid,
  output data_t out_data,
  output logic  out_corrected,
  output logic  out_uncorrectable
);

  synd_t    synd;
  logic     par_odd;
  rx_kind_e kind;
  code_t    repaired;

  data_t data_d, data_q;
  logic  valid_d, valid_q;
  logic  corr_d, corr_q;
  logic  fail_d, fail_q;

  always_comb begin
    synd    = syndrome_of(rx_word);
    par_odd = ^rx_word;
    if (!par_odd) begin
      kind = (synd == '0) ? KIND_CLEAN : KIND_DOUBLE;
    end else if (32'(synd) <= LAST_POS) begin
      kind = KIND_SINGLE;
    end else begin
      kind = KIND_BEYOND;
    end
  end

  always_comb begin
    repaired = rx_word;
    if (kind == KIND_SINGLE) begin
      repaired[synd] = ~rx_word[synd];
    end
  end

  assign hit_single = rx_valid && (kind == KIND_SINGLE);
  assign hit_fail   = rx_valid && ((kind == KIND_DOUBLE) || (kind == KIND_BEYOND));

  always_comb begin
    valid_d = rx_valid;
    corr_d  = hit_single;
    fail_d  = hit_fail;
    data_d  = rx_valid ? extract_data(repaired) : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      corr_q  <= 1'b0;
      fail_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      corr_q  <= corr_d;
      fail_q  <= fail_d;
      data_q  <= data_d;
    end
  end

  assign out_valid         = valid_q;
  assign out_data          = data_q;
  assign out_corrected     = corr_q;
  assign out_uncorrectable = fail_q;

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != TOP)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/link_secded_codec.sv
module link_secded_codec
  import secded_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      in_data,
  output logic             enc_valid,
  output logic [71:0]      enc_word,
  input  logic             rx_valid,
  input  logic [71:0]      rx_word,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic             out_corrected,
  output logic             out_uncorrectable,
  output logic [CNT_W-1:0] corr_count,
  output logic [CNT_W-1:0] uncorr_count
);

  localparam int unsigned N_CNT = 2;

  logic             hit_single, hit_fail;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  secded_encoder enc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .enc_valid (enc_valid),
    .enc_word  (enc_word)
  );

  secded_decoder dec_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .rx_valid          (rx_valid),
    .rx_word           (rx_word),
    .hit_single        (hit_single),
    .hit_fail          (hit_fail),
    .out_valid         (out_valid),
    .out_data          (out_data),
    .out_corrected     (out_corrected),
    .out_uncorrectable (out_uncorrectable)
  );

  assign cnt_inc = {hit_fail, hit_single};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign corr_count   = cnt_val[0];
  assign uncorr_count = cnt_val[1];

endmodule

// File: rtl/secded_codec_checker.sv
module secded_codec_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [63:0]      in_data,
  input logic             enc_valid,
  input logic [71:0]      enc_word,
  input logic             rx_valid,
  input logic [71:0]      rx_word,
  input logic             out_valid,
  input logic [63:0]      out_data,
  input logic             out_corrected,
  input logic             out_uncorrectable,
  input logic [CNT_W-1:0] corr_count,
  input logic [CNT_W-1:0] uncorr_count
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R1: every emitted codeword has even overall parity
  a_r1_enc_parity: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> (^enc_word) == 1'b0);

  // R2: one-cycle valid latency and hold of the codeword
  a_r2_enc_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> enc_valid);
  a_r2_enc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!enc_valid && $stable(enc_word)));

  // R3: decoder output follows rx_valid after one cycle
  a_r3_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> out_valid);

  // R7: idle input leaves flags low and data held; flags exclusive
  a_r7_dec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!out_valid && !out_corrected && !out_uncorrectable && $stable(out_data)));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_uncorrectable));

  // R8: counters step with their flag and saturate
  a_r8_corr_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_corrected |-> corr_count == (($past(corr_count) == CMAX) ? CMAX : $past(corr_count) + 1'b1));
  a_r8_corr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !out_corrected |-> $stable(corr_count));
  a_r8_unc_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncorrectable |-> uncorr_count == (($past(uncorr_count) == CMAX) ? CMAX : $past(uncorr_count) + 1'b1));
  a_r8_unc_still: assert property (@(posedge clk) disable iff (!rst_n)
    !out_uncorrectable |-> $stable(uncorr_count));

endmodule

bind link_secded_codec secded_codec_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/link_secded_codec_tb_top.sv
module link_secded_codec_tb_top;

  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [63:0]   in_data;
  logic          enc_valid;
  logic [71:0]   enc_word;
  logic          rx_valid;
  logic [71:0]   rx_word;
  logic          out_valid;
  logic [63:0]   out_data;
  logic          out_corrected;
  logic          out_uncorrectable;
  logic [CW-1:0] corr_count;
  logic [CW-1:0] uncorr_count;

  int  tests  = 0;
  int  failed = 0;
  bit  done   = 0;

  // model state
  logic [71:0] m_enc_word;
  logic        m_enc_valid;
  logic [63:0] m_out_data;
  logic        m_out_valid, m_corr, m_unc;
  int          m_cc, m_uc;
  int          dpos [64];

  always #4 clk = ~clk;

  link_secded_codec #(.CNT_W(CW)) dut_i (.*);

  function automatic bit pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword built per data bit from the layout in R1
  function automatic logic [71:0] ref_encode(logic [63:0] d);
    logic [71:0] w;
    w = '0;
    for (int i = 0; i < 64; i++) begin
      if (d[i]) begin
        w[dpos[i]] = 1'b1;
        for (int b = 0; b < 7; b++)
          if (dpos[i][b]) w[1 << b] = ~w[1 << b];
      end
    end
    w[0] = ^w[71:1];
    return w;
  endfunction

  function automatic logic [63:0] ref_data(logic [71:0] w);
    logic [63:0] d;
    for (int i = 0; i < 64; i++) d[i] = w[dpos[i]];
    return d;
  endfunction

  task automatic chk(string req, string what, logic [71:0] act, logic [71:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "enc_valid", 72'(enc_valid), 72'(m_enc_valid));
    chk(req, "enc_word", enc_word, m_enc_word);
    chk(req, "out_valid", 72'(out_valid), 72'(m_out_valid));
    chk(req, "out_data", 72'(out_data), 72'(m_out_data));
    chk(req, "out_corrected", 72'(out_corrected), 72'(m_corr));
    chk(req, "out_uncorrectable", 72'(out_uncorrectable), 72'(m_unc));
    chk("R8", "corr_count", 72'(corr_count), 72'(m_cc));
    chk("R8", "uncorr_count", 72'(uncorr_count), 72'(m_uc));
  endtask

  // one clock: drive both paths, advance the model, compare
  task automatic step(logic iv, logic [63:0] id, logic rv, logic [63:0] payload,
                      int nflip, int f0, int f1, int f2, string req);
    logic [71:0] w;
    int          lim;
    lim = (1 << CW) - 1;
    w = ref_encode(payload);
    if (nflip > 0) w[f0] = ~w[f0];
    if (nflip > 1) w[f1] = ~w[f1];
    if (nflip > 2) w[f2] = ~w[f2];
    in_valid = iv; in_data = id; rx_valid = rv; rx_word = w;
    m_enc_valid = iv;
    if (iv) m_enc_word = ref_encode(id);
    m_out_valid = rv;
    m_corr = rv && (nflip == 1);
    m_unc  = rv && (nflip >= 2);
    if (rv) m_out_data = m_unc ? ref_data(w) : payload;
    if (m_corr && m_cc < lim) m_cc++;
    if (m_unc && m_uc < lim) m_uc++;
    @(negedge clk);
    compare_all(req);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    begin
      int k;
      k = 0;
      for (int p = 1; p < 72; p++) if (!pow2(p)) begin dpos[k] = p; k++; end
    end
    rst_n = 1'b0; in_valid = 0; in_data = '0; rx_valid = 0; rx_word = '0;
    m_enc_word = '0; m_enc_valid = 0; m_out_data = '0;
    m_out_valid = 0; m_corr = 0; m_unc = 0; m_cc = 0; m_uc = 0;
    repeat (3) @(negedge clk);
    compare_all("R9");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 fixed layout points
    step(1, 64'h1, 0, '0, 0, 0, 0, 0, "R1");
    chk("R1", "enc_word 64'h1", enc_word, 72'hF);
    step(1, 64'h0, 0, '0, 0, 0, 0, 0, "R1");
    chk("R1", "enc_word zero", enc_word, 72'h0);
    for (int i = 0; i < 20; i++) step(1, rnd64(), 0, '0, 0, 0, 0, 0, "R1");

    // R2 hold while idle
    step(1, 64'hDEAD_BEEF_0123_4567, 0, '0, 0, 0, 0, 0, "R2");
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, '0, 0, 0, 0, 0, "R2");
    step(0, 64'h0, 0, '0, 0, 0, 0, 0, "R2");

    // R3 clean words
    for (int i = 0; i < 10; i++) step(0, '0, 1, rnd64(), 0, 0, 0, 0, "R3");
    step(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "R3");

    // R7 idle decoder holds data, clears flags
    step(0, '0, 0, 64'h1234, 0, 0, 0, 0, "R7");
    step(0, '0, 0, 64'h5678, 1, 5, 0, 0, "R7");

    // R4 single flip at every position, counter saturates (R8)
    for (int p = 0; p < 72; p++) step(1, rnd64(), 1, rnd64(), 1, p, 0, 0, "R4");
    step(0, '0, 0, '0, 0, 0, 0, 0, "R7");

    // R5 double flips, including parity and check bits
    step(0, '0, 1, rnd64(), 2, 0, 1, 0, "R5");
    step(0, '0, 1, rnd64(), 2, 3, 70, 0, "R5");
    step(0, '0, 1, rnd64(), 2, 64, 71, 0, "R5");
    for (int i = 0; i < 20; i++) step(0, '0, 1, rnd64(), 2, i + 1, 71 - i, 0, "R5");

    // R6 triple flip with syndrome 64^12^6 = 74
    step(0, '0, 1, rnd64(), 3, 64, 12, 6, "R6");
    step(0, '0, 1, 64'h0, 3, 64, 12, 6, "R6");

    step(0, '0, 0, '0, 0, 0, 0, 0, "R7");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule